// File: doc/BRIEF.md
# Read-Sample Delay Calibration Engine

This engine picks the read-sample delay code for a serial flash interface. Each time the requested clock rate for a chip select changes, it first captures a reference three-byte ID at the safe 50 MHz rate. It then steps the delay code upward at the target rate and repeats the ID read at each step. The passing window it finds decides the operating code. That code is written to the delay control register of the chip select.

Trial reads go out through a one-cycle start pulse. The engine waits for a done pulse that carries the returned ID. A failed calibration clears the delay line and raises a request to fall back to the safe clock. If the target rate does not need calibration, the delay line is simply cleared.

Top module: `dtr_engine`

## Requirements
- R1: Delay register writes (`dly_val`, 16 bits) carry the code in bits [8:0] and an enable flag in bit 15, with all other bits zero. A code of zero is written as an all-zero word.
- R2: The highest delay code is 255 by default, or 511 when `WIDE_VARIANT` is set. No written code exceeds it, because any larger code is clamped.
- R3: A request is ignored when its rate equals the last accepted rate of the same chip select. Ignored means no busy, no done and no register write. Rates are stored separately for each of the two chip selects, and both stored rates are 0 after reset.
- R4: A new rate of 50 MHz or less starts no trial reads. In the cycle after the request it writes 0 to that chip select's delay register and pulses `done` with `result` = 01 (bypass) and `pass` = 0.
- R5: The reference read is issued with `rd_slow` = 1, and `rd_id[23:16]` is the first ID byte and `rd_id[15:8]` the second. If those two bytes are both 0xFF or both 0x00, the engine ends with `result` = 10 (no device), with no register write and no fallback.
- R6: Trial codes run 0, 10, 20 and so on, each preceded by a delay register write of that code and issued with `rd_slow` = 0. When the next step would pass the highest code, the final trial is made at exactly the highest code.
- R7: The first trial whose 24-bit ID equals the reference sets the left edge. The first mismatch after a match sets the right edge to the previous trial code and ends the sweep. If no such mismatch occurs, the right edge is the last code tried.
- R8: Calibration passes only if some trial matched and the width (right minus left) is at least 80.
- R9: On a pass, the chosen code is left + (2·width)/5 when left is 0 and right is below the highest code. In every other passing case it is left + width/2. Integer division is used.
- R10: On a failure, the engine writes 0 to the delay register, pulses `fallback`, and reports `result` = 11 with `code` = 0.
- R11: `busy` is high from the cycle after an accepted calibration request until the cycle `done` pulses. `done` is a one-cycle pulse, and `pass`, `result` and `code` hold their values until the next `done`. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Rate request strobe |
| req_cs | input | 1 | Chip select of the request |
| req_mhz | input | 10 | Requested clock rate in MHz |
| rd_start | output | 1 | One-cycle ID read request |
| rd_slow | output | 1 | 1: read at the safe rate (reference), 0: target rate |
| rd_done | input | 1 | ID read complete, `rd_id` valid |
| rd_id | input | 24 | Returned ID, first byte in [23:16] |
| dly_we | output | 1 | Delay register write strobe |
| dly_cs | output | 1 | Chip select of the register write |
| dly_val | output | 16 | Delay register value |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | End-of-request pulse |
| pass | output | 1 | Calibration succeeded |
| result | output | 2 | 00 trained, 01 bypass, 10 no device, 11 failed |
| code | output | 9 | Chosen delay code, 0 unless trained |
| fallback | output | 1 | Pulse requesting the safe 50 MHz clock |

## Verification
The bench places the passing window of a simulated flash at chosen code ranges. Windows that start at zero and end short of the top separate the 2/5 pick from the midpoint pick, and widths of 70, 80 and 90 sit on both sides of the minimum. A window reaching the highest code exercises the clamped last trial and the midpoint pick, and an empty window or a late narrow window exercises the failure path. Mismatch IDs differ only in the third byte, so a partial compare is exposed. Random windows, chip selects and read latencies are compared with a bench model of the trial sequence, and repeated rates, low rates and absent-device IDs test the paths that skip the sweep.

// File: rtl/dtr_pkg.sv
// Shared types for the delay calibration engine.
// Assumes: two-bit outcome code visible at the top ports.
package dtr_pkg;

    typedef enum logic [1:0] {
        RES_TRAINED = 2'b00,
        RES_BYPASS  = 2'b01,
        RES_NODEV   = 2'b10,
        RES_FAIL    = 2'b11
    } dtr_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_REF_WAIT,
        ST_SET,
        ST_TRY,
        ST_TRY_WAIT,
        ST_PICK
    } dtr_state_e;

endpackage

// File: rtl/dtr_reg_fmt.sv
// Formats a delay code into the delay control register word.
// Clamps the code to CODE_MAX. A zero code gives an all-zero word
// (delay line off); otherwise the enable flag is set.
module dtr_reg_fmt #(
    parameter int              CODE_W   = 9,
    parameter int              REG_W    = 16,
    parameter int              EN_BIT   = 15,
    parameter logic [8:0]      CODE_MAX = 9'd255
) (
    input  logic [CODE_W-1:0] code_in,
    output logic [REG_W-1:0]  reg_val
);
    logic [CODE_W-1:0] clamped;

    // Clamp and pack the code with its enable flag.
    always_comb begin
        clamped = (code_in > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : code_in;
        reg_val = '0;
        if (clamped != '0) begin
            reg_val[EN_BIT]       = 1'b1;
            reg_val[CODE_W-1:0]   = clamped;
        end
    end
endmodule

// File: rtl/dtr_window_pick.sv
// Decides pass/fail and the operating code from the swept window.
// Assumes right >= left whenever seen is set.
module dtr_window_pick #(
    parameter int          CODE_W   = 9,
    parameter int          MIN_WIN  = 80,
    parameter logic [8:0]  CODE_MAX = 9'd255
) (
    input  logic              seen,
    input  logic [CODE_W-1:0] left,
    input  logic [CODE_W-1:0] right,
    output logic              ok,
    output logic [CODE_W-1:0] chosen
);
    logic [CODE_W-1:0] width;
    logic [CODE_W:0]   two_fifths;

    // Width test and the choice between the 2/5 point and the midpoint.
    always_comb begin
        width      = right - left;
        two_fifths = {width, 1'b0} / (CODE_W+1)'(5);
        ok         = seen && (width >= CODE_W'(MIN_WIN));
        if ((left == '0) && (right < CODE_W'(CODE_MAX)))
            chosen = left + two_fifths[CODE_W-1:0];
        else
            chosen = left + (width >> 1);
    end
endmodule

// File: rtl/dtr_speed_tags.sv
// Per-chip-select store of the last accepted clock rate.
// Assumes: written only when a new rate is accepted; zero after reset.
module dtr_speed_tags #(
    parameter int NUM_CS  = 2,
    parameter int CS_W    = 1,
    parameter int SPEED_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CS_W-1:0]    wr_cs,
    input  logic [SPEED_W-1:0] wr_speed,
    input  logic [CS_W-1:0]    rd_cs,
    output logic [SPEED_W-1:0] rd_speed
);
    logic [NUM_CS-1:0][SPEED_W-1:0] tag_vec;

    for (genvar g = 0; g < NUM_CS; g++) begin : gen_tag
        logic [SPEED_W-1:0] q;
        // Hold the rate of chip select g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_cs == CS_W'(g)))
                q <= wr_speed;
        end
        assign tag_vec[g] = q;
    end

    assign rd_speed = tag_vec[rd_cs];
endmodule

// File: rtl/dtr_engine.sv
// Read-sample delay calibration engine (top).
// Captures a reference ID at the safe rate, sweeps delay codes at the
// target rate, and programs the chosen code. Assumes rd_done arrives only
// after an rd_start and that the requester holds a rate request one cycle.
module dtr_engine #(
    parameter int NUM_CS       = 2,
    parameter int SPEED_W      = 10,
    parameter int CODE_W       = 9,
    parameter int WIDE_VARIANT = 0,
    parameter int STEP         = 10,
    parameter int MIN_WIN      = 80,
    parameter int SAFE_MHZ     = 50,
    parameter int REG_W        = 16,
    parameter int EN_BIT       = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [0:0]         req_cs,
    input  logic [SPEED_W-1:0] req_mhz,
    output logic               rd_start,
    output logic               rd_slow,
    input  logic               rd_done,
    input  logic [23:0]        rd_id,
    output logic               dly_we,
    output logic [0:0]         dly_cs,
    output logic [REG_W-1:0]   dly_val,
    output logic               busy,
    output logic               done,
    output logic               pass,
    output logic [1:0]         result,
    output logic [CODE_W-1:0]  code,
    output logic               fallback
);
    import dtr_pkg::*;

    localparam int         CS_W     = 1;
    localparam logic [8:0] CODE_MAX = (WIDE_VARIANT != 0) ? 9'h1FF : 9'h0FF;

    dtr_state_e         state;
    logic [CS_W-1:0]    cs_r;
    logic [23:0]        ref_id;
    logic [CODE_W-1:0]  cur, prev, left_r, right_r;
    logic               seen;

    logic [SPEED_W-1:0] tag_speed;
    logic               accept;
    logic [CODE_W:0]    nxt_raw;
    logic [CODE_W-1:0]  nxt;
    logic               absent, match;
    logic               pick_ok;
    logic [CODE_W-1:0]  pick_code;
    logic [REG_W-1:0]   cur_word, pick_word;

    // A request is taken only when idle and its rate differs from the stored one.
    assign accept = (state == ST_IDLE) && req_valid && (req_mhz != tag_speed);

    // Next sweep code, clamped so the last trial lands on the highest code.
    always_comb begin
        nxt_raw = {1'b0, cur} + (CODE_W+1)'(STEP);
        nxt     = (nxt_raw > (CODE_W+1)'(CODE_MAX)) ? CODE_W'(CODE_MAX) : nxt_raw[CODE_W-1:0];
    end

    // Device-absent detection on the reference ID and per-trial compare.
    always_comb begin
        absent = (rd_id[23:16] == rd_id[15:8]) &&
                 ((rd_id[23:16] == 8'hFF) || (rd_id[23:16] == 8'h00));
        match  = (rd_id == ref_id);
    end

    dtr_speed_tags #(.NUM_CS(NUM_CS), .CS_W(CS_W), .SPEED_W(SPEED_W)) tags_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_cs(req_cs), .wr_speed(req_mhz),
        .rd_cs(req_cs), .rd_speed(tag_speed)
    );

    dtr_window_pick #(.CODE_W(CODE_W), .MIN_WIN(MIN_WIN), .CODE_MAX(CODE_MAX)) pick_i (
        .seen(seen), .left(left_r), .right(right_r),
        .ok(pick_ok), .chosen(pick_code)
    );

    dtr_reg_fmt #(.CODE_W(CODE_W), .REG_W(REG_W), .EN_BIT(EN_BIT), .CODE_MAX(CODE_MAX)) fmt_cur_i (
        .code_in(cur), .reg_val(cur_word)
    );

    dtr_reg_fmt #(.CODE_W(CODE_W), .REG_W(REG_W), .EN_BIT(EN_BIT), .CODE_MAX(CODE_MAX)) fmt_pick_i (
        .code_in(pick_code), .reg_val(pick_word)
    );

    // Sequencer: reference read, stepped sweep, pick and register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cs_r     <= '0;
            ref_id   <= '0;
            cur      <= '0;
            prev     <= '0;
            left_r   <= '0;
            right_r  <= '0;
            seen     <= 1'b0;
            rd_start <= 1'b0;
            rd_slow  <= 1'b0;
            dly_we   <= 1'b0;
            dly_cs   <= '0;
            dly_val  <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            pass     <= 1'b0;
            result   <= 2'b00;
            code     <= '0;
            fallback <= 1'b0;
        end else begin
            rd_start <= 1'b0;
            dly_we   <= 1'b0;
            done     <= 1'b0;
            fallback <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cs_r <= req_cs;
                        if (req_mhz <= SPEED_W'(SAFE_MHZ)) begin
                            dly_we  <= 1'b1;
                            dly_cs  <= req_cs;
                            dly_val <= '0;
                            done    <= 1'b1;
                            pass    <= 1'b0;
                            result  <= RES_BYPASS;
                            code    <= '0;
                        end else begin
                            busy  <= 1'b1;
                            state <= ST_REF;
                        end
                    end
                end
                ST_REF: begin
                    rd_start <= 1'b1;
                    rd_slow  <= 1'b1;
                    state    <= ST_REF_WAIT;
                end
                ST_REF_WAIT: begin
                    if (rd_done) begin
                        if (absent) begin
                            done   <= 1'b1;
                            busy   <= 1'b0;
                            pass   <= 1'b0;
                            result <= RES_NODEV;
                            code   <= '0;
                            state  <= ST_IDLE;
                        end else begin
                            ref_id <= rd_id;
                            cur    <= '0;
                            prev   <= '0;
                            left_r <= '0;
                            seen   <= 1'b0;
                            state  <= ST_SET;
                        end
                    end
                end
                ST_SET: begin
                    dly_we  <= 1'b1;
                    dly_cs  <= cs_r;
                    dly_val <= cur_word;
                    state   <= ST_TRY;
                end
                ST_TRY: begin
                    rd_start <= 1'b1;
                    rd_slow  <= 1'b0;
                    state    <= ST_TRY_WAIT;
                end
                ST_TRY_WAIT: begin
                    if (rd_done) begin
                        if (seen && !match) begin
                            right_r <= prev;
                            state   <= ST_PICK;
                        end else begin
                            if (match && !seen)
                                left_r <= cur;
                            if (match)
                                seen <= 1'b1;
                            prev <= cur;
                            if (cur == CODE_W'(CODE_MAX)) begin
                                right_r <= cur;
                                state   <= ST_PICK;
                            end else begin
                                cur   <= nxt;
                                state <= ST_SET;
                            end
                        end
                    end
                end
                ST_PICK: begin
                    done     <= 1'b1;
                    busy     <= 1'b0;
                    pass     <= pick_ok;
                    result   <= pick_ok ? RES_TRAINED : RES_FAIL;
                    code     <= pick_ok ? pick_code : '0;
                    dly_we   <= 1'b1;
                    dly_cs   <= cs_r;
                    dly_val  <= pick_ok ? pick_word : '0;
                    fallback <= !pick_ok;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dtr_engine_chk.sv
// Protocol checker for dtr_engine, attached by bind.
// Assumes the default register layout (enable at bit 15).
module dtr_engine_chk #(
    parameter int         CODE_W   = 9,
    parameter int         MIN_WIN  = 80,
    parameter logic [8:0] CODE_MAX = 9'd255
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_start,
    input logic              dly_we,
    input logic [15:0]       dly_val,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic [1:0]        result,
    input logic [CODE_W-1:0] code,
    input logic              fallback
);
    AST_REG_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dly_we |-> (dly_val[15] == (dly_val[CODE_W-1:0] != '0))); // R1
    AST_REG_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dly_we |-> (dly_val[14:CODE_W] == '0)); // R1
    AST_CODE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        dly_we |-> (dly_val[CODE_W-1:0] <= CODE_W'(CODE_MAX))); // R2
    AST_NODEV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result == 2'b10)) |-> (!dly_we && !fallback)); // R5
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start); // R6
    AST_PASS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (code >= CODE_W'((MIN_WIN * 2) / 5))); // R8
    AST_FALLBACK_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        fallback |-> (done && !pass && (result == 2'b11) && (code == '0))); // R10
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> busy); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
endmodule

bind dtr_engine dtr_engine_chk #(.CODE_W(CODE_W), .MIN_WIN(MIN_WIN), .CODE_MAX(CODE_MAX)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .dly_we(dly_we),
    .dly_val(dly_val), .busy(busy), .done(done), .pass(pass),
    .result(result), .code(code), .fallback(fallback)
);

// File: tb/dtr_engine_tb.sv
// Bench for dtr_engine: flash ID responder with a configurable passing
// window, directed corner cases and seeded random windows.
module dtr_engine_tb_top;
    localparam int CMAX = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [0:0]  req_cs = '0;
    logic [9:0]  req_mhz = '0;
    logic        rd_start, rd_slow;
    logic        rd_done = 1'b0;
    logic [23:0] rd_id = '0;
    logic        dly_we;
    logic [0:0]  dly_cs;
    logic [15:0] dly_val;
    logic        busy, done, pass, fallback;
    logic [1:0]  result;
    logic [8:0]  code;

    always #2 clk = ~clk;

    dtr_engine dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
        .req_mhz(req_mhz), .rd_start(rd_start), .rd_slow(rd_slow),
        .rd_done(rd_done), .rd_id(rd_id), .dly_we(dly_we), .dly_cs(dly_cs),
        .dly_val(dly_val), .busy(busy), .done(done), .pass(pass),
        .result(result), .code(code), .fallback(fallback)
    );

    int checks = 0;
    int errors = 0;

    // flash model settings
    logic [23:0] f_ref = 24'h1A2B3C;
    int          f_lo = 0, f_hi = 0, f_absent = 0;
    // monitor state
    int          cur_code [2];
    int          wr_count = 0, done_count = 0, ntrial = 0;
    logic [15:0] last_wval = '0;
    int          last_wcs = 0;
    logic        saw_busy = 1'b0;
    int          trial_codes [64];
    int          tag_model [2];

    task automatic chk(input logic cond, input string what, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Responder and monitor: runs every falling edge.
    initial begin
        int pend;
        logic slow;
        pend = 0;
        slow = 1'b0;
        cur_code[0] = 0;
        cur_code[1] = 0;
        forever begin
            @(negedge clk);
            if (dly_we) begin
                wr_count++;
                last_wval = dly_val;
                last_wcs  = int'(dly_cs);
                cur_code[dly_cs] = dly_val[15] ? int'(dly_val[8:0]) : 0;
            end
            if (busy) saw_busy = 1'b1;
            if (done) done_count++;
            rd_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rd_done = 1'b1;
                    if (slow)
                        rd_id = (f_absent == 1) ? 24'hFFFF5A :
                                (f_absent == 2) ? 24'h0000A5 : f_ref;
                    else
                        rd_id = (cur_code[last_wcs] >= f_lo && cur_code[last_wcs] <= f_hi)
                                ? f_ref : (f_ref ^ 24'h000001);
                end
            end
            if (rd_start) begin
                pend = 1 + int'($urandom % 4);
                slow = rd_slow;
                if (!rd_slow) begin
                    if (ntrial < 64) trial_codes[ntrial] = cur_code[last_wcs];
                    ntrial++;
                end
            end
        end
    end

    // Reference model of the sweep and pick, from R6..R9.
    task automatic model(input int lo, input int hi, output int ok, output int chosen,
                         output int trials, output int seq [64]);
        int cur, prev, left, right, seen, m, w;
        cur = 0; prev = 0; left = 0; right = 0; seen = 0; trials = 0;
        for (int i = 0; i < 64; i++) begin
            seq[trials] = cur;
            trials++;
            m = (cur >= lo && cur <= hi) ? 1 : 0;
            if (seen == 1 && m == 0) begin right = prev; break; end
            if (m == 1 && seen == 0) left = cur;
            if (m == 1) seen = 1;
            prev = cur;
            if (cur == CMAX) begin right = cur; break; end
            cur = (cur + 10 > CMAX) ? CMAX : cur + 10;
        end
        w = right - left;
        ok = (seen == 1 && w >= 80) ? 1 : 0;
        if (left == 0 && right < CMAX) chosen = left + (w * 2) / 5;
        else chosen = left + w / 2;
        if (ok == 0) chosen = 0;
    endtask

    task automatic run_req(input int cs, input int mhz, input int lo, input int hi,
                           input int absent, input string tag);
        int ok, chosen, trials, n;
        int seq [64];
        logic c_pass, c_fb;
        logic [1:0] c_res;
        logic [8:0] c_code;
        logic [15:0] exp_w;
        f_lo = lo; f_hi = hi; f_absent = absent;
        f_ref = 24'h100000 | 24'($urandom % 24'h0FFFFF);
        wr_count = 0; done_count = 0; ntrial = 0; saw_busy = 1'b0;
        req_valid = 1'b1; req_cs = 1'(cs); req_mhz = 10'(mhz);
        @(negedge clk);
        req_valid = 1'b0;
        if (mhz == tag_model[cs]) begin
            repeat (12) @(negedge clk);
            chk(done_count == 0 && wr_count == 0 && !saw_busy && ntrial == 0,
                {tag, " R3 repeated rate ignored"}, done_count + wr_count + ntrial, 0);
            return;
        end
        tag_model[cs] = mhz;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        c_pass = pass; c_res = result; c_code = code; c_fb = fallback;
        @(negedge clk);
        if (mhz <= 50) begin
            chk(c_res == 2'b01 && !c_pass, {tag, " R4 bypass result"}, int'(c_res), 1);
            chk(wr_count == 1 && last_wval == 16'h0 && last_wcs == cs,
                {tag, " R4 zero write"}, int'(last_wval), 0);
            chk(ntrial == 0 && !saw_busy && !c_fb, {tag, " R4 no trials"}, ntrial, 0);
        end else if (absent != 0) begin
            chk(c_res == 2'b10 && !c_pass, {tag, " R5 no device result"}, int'(c_res), 2);
            chk(wr_count == 0 && ntrial == 0 && !c_fb, {tag, " R5 no write no trial"}, wr_count, 0);
            chk(saw_busy, {tag, " R11 busy seen"}, int'(saw_busy), 1);
        end else begin
            model(lo, hi, ok, chosen, trials, seq);
            exp_w = (ok == 1 && chosen != 0) ? (16'h8000 | 16'(chosen)) : 16'h0;
            chk(int'(c_pass) == ok, {tag, " R8 pass flag"}, int'(c_pass), ok);
            chk(int'(c_code) == chosen, {tag, " R9 chosen code"}, int'(c_code), chosen);
            chk(c_res == ((ok == 1) ? 2'b00 : 2'b11), {tag, " R10 result"}, int'(c_res), (ok == 1) ? 0 : 3);
            chk(int'(c_fb) == 1 - ok, {tag, " R10 fallback"}, int'(c_fb), 1 - ok);
            chk(last_wval == exp_w && last_wcs == cs, {tag, " R1 final register"},
                int'(last_wval), int'(exp_w));
            chk(ntrial == trials && wr_count == trials + 1, {tag, " R7 trial count"}, ntrial, trials);
            begin
                int bad = 0;
                for (int i = 0; i < trials && i < 64; i++)
                    if (trial_codes[i] != seq[i]) bad++;
                chk(bad == 0, {tag, " R6 trial code order"}, bad, 0);
            end
            chk(saw_busy, {tag, " R11 busy seen"}, int'(saw_busy), 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int spd;
        void'($urandom(32'h5EED));
        tag_model[0] = 0;
        tag_model[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_start && !dly_we && !fallback && result == 2'b00,
            "R11 reset outputs", int'(busy), 0);
        run_req(0, 0, 0, 0, 0, "reset rate");
        run_req(0, 40, 0, 0, 0, "low rate");
        run_req(1, 50, 0, 0, 0, "rate at limit");
        run_req(0, 100, 0, 255, 1, "absent FF");
        run_req(1, 120, 0, 255, 2, "absent 00");
        run_req(0, 130, 0, 95, 0, "zero-start 90");
        run_req(0, 131, 0, 85, 0, "width 80");
        run_req(0, 132, 0, 75, 0, "width 70");
        run_req(1, 140, 0, 255, 0, "full window");
        run_req(1, 141, 100, 250, 0, "upper window");
        run_req(0, 133, 20, 130, 0, "middle window");
        run_req(0, 134, 200, 255, 0, "late narrow");
        run_req(1, 142, 300, 0, 0, "empty window");
        run_req(1, 142, 0, 255, 0, "same rate cs1");
        run_req(0, 142, 0, 255, 0, "same rate other cs");
        spd = 200;
        for (int k = 0; k < 30; k++) begin
            int lo, hi, cs;
            lo = int'($urandom % 256);
            hi = lo + int'($urandom % (256 - lo));
            cs = int'($urandom % 2);
            spd++;
            run_req(cs, spd, lo, hi, 0, "random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule